// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven by a slow tick-enable input. Software controls it through one control word written at offset 0x40 and observes it through a status word read at offset 0x44. The control word carries a 9-bit reload count, a run flag and a 7-bit key. Once the watchdog has been armed, a refresh is taken only when its key is the bitwise inverse of the key last taken. A stray or repeated write therefore cannot keep a runaway program alive.

Expiry happens in two steps. When the counter first runs out, the block raises a non-maskable interrupt and reloads a short grace count. A handler can still refresh the watchdog during that grace period, which also clears the interrupt. If the grace count runs out as well, the block emits a one-cycle reset-request pulse and stops.

The control and status pins are plain strobes with no flow control. A write is taken in the cycle `wr_en` is high, and the status read is combinational from `rd_addr`.

Top module: `keyed_wdog`

## Requirements
- R1: After reset, `nmi` and `reset_req` are 0, the status word reads 0, the counter is stopped, and the first control write is taken whatever its key.
- R2: A control write has `wr_en`=1 and `wr_addr`=0x40. Its word is split as follows: bits 8:0 are the reload count, bit 8 alone is the run flag, and bits 15:9 are the key. While the watchdog is disarmed (last taken run flag 0), any control write is taken.
- R3: While the watchdog is armed, a control write whose key is not the bitwise inverse of the stored key is discarded: the counter, the interrupt and the stored key keep their values.
- R4: A write that is taken stores its key and run flag, loads the counter from bits 8:0 and clears `nmi`. A write takes priority over a tick in the same cycle.
- R5: When the run flag of the write taken is 0, the counter holds on ticks and the key check is disabled again.
- R6: While running, the counter drops by one in each cycle with `tick`=1 and holds when `tick`=0.
- R7: A tick that finds the counter at 1 or below in the armed stage sets `nmi` and loads the counter with GRACE (default 1).
- R8: A tick that finds the counter at 1 or below in the grace stage drives `reset_req` high for exactly one cycle and stops the counter at 0. `nmi` stays high.
- R9: Reading `rd_addr`=0x44 returns the counter in bits 8:0, `nmi` in bit 9 and zeros above. Any other read address returns 0.
- R10: Writes to any address other than 0x40 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow count enable, one pulse per watchdog tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data |
| nmi | output | 1 | Non-maskable interrupt, first expiry |
| reset_req | output | 1 | One-cycle system reset request, second expiry |

## Verification
The bench drives the control path with four kinds of write and checks each one at the status word. A disarmed write carrying an arbitrary key must be taken. An armed write carrying the inverted key must be taken. An armed write carrying a repeated, non-inverted key must be dropped. A write to the status offset must change nothing. Telling these apart shows that the key gate decides on the stored run flag and on the inverse relation, and not on the address alone.

The countdown is driven with ticks on and off, with and without the run flag set. This separates tick gating from run gating. Full expiry runs, one with a refresh taken during the grace period and one without, separate the interrupt stage from the reset stage.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
  localparam int RUN_BIT = 8;
  localparam int KEY_LSB = 9;
  typedef enum logic {ST_ARMED = 1'b0, ST_GRACE = 1'b1} wd_stage_e;
endpackage

// File: rtl/wdog_keygate.sv
`timescale 1ns/1ps
module wdog_keygate #(
  parameter int KEY_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             wr_run,
  output logic             accept,
  output logic             en_q,
  output logic [KEY_W-1:0] key_q
);
  logic key_ok;

  assign key_ok = (wr_key == ~key_q);
  assign accept = wr_hit && (!en_q || key_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      key_q <= '0;
    end else if (accept) begin
      en_q  <= wr_run;
      key_q <= wr_key;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int GRACE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             nmi_q,
  output logic             rst_req_q
);
  localparam logic [CNT_W-1:0] GRACE_V = CNT_W'(GRACE);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic      run_q;
  wd_stage_e stage_q;
  logic      ran_out;

  assign ran_out = (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      nmi_q     <= 1'b0;
      rst_req_q <= 1'b0;
      stage_q   <= ST_ARMED;
    end else begin
      rst_req_q <= 1'b0;
      if (load) begin
        cnt_q   <= load_val;
        run_q   <= load_run;
        nmi_q   <= 1'b0;
        stage_q <= ST_ARMED;
      end else if (run_q && tick) begin
        if (!ran_out) begin
          cnt_q <= cnt_q - ONE;
        end else if (stage_q == ST_ARMED) begin
          nmi_q   <= 1'b1;
          stage_q <= ST_GRACE;
          cnt_q   <= GRACE_V;
        end else begin
          rst_req_q <= 1'b1;
          run_q     <= 1'b0;
          cnt_q     <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/wdog_status.sv
`timescale 1ns/1ps
module wdog_status #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 9,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h44
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              nmi,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - CNT_W - 1;

  always_comb begin
    rd_data = '0;
    if (rd_addr == STAT_ADDR) rd_data = {{PAD_W{1'b0}}, nmi, cnt};
  end
endmodule

// File: rtl/keyed_wdog.sv
`timescale 1ns/1ps
module keyed_wdog
  import wdog_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 9,
  parameter int                KEY_W     = 7,
  parameter int                GRACE     = 1,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h40,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              nmi,
  output logic              reset_req
);
  logic             wr_hit;
  logic [KEY_W-1:0] wr_key;
  logic             wr_run;
  logic             accept;
  logic             en_q;
  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt_q;

  assign wr_hit = wr_en && (wr_addr == CTRL_ADDR);
  assign wr_key = wr_data[KEY_LSB +: KEY_W];
  assign wr_run = wr_data[RUN_BIT];

  wdog_keygate #(.KEY_W(KEY_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_key(wr_key),
    .wr_run(wr_run), .accept(accept), .en_q(en_q), .key_q(key_q)
  );

  wdog_counter #(.CNT_W(CNT_W), .GRACE(GRACE)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(accept),
    .load_val(wr_data[CNT_W-1:0]), .load_run(wr_run),
    .cnt_q(cnt_q), .nmi_q(nmi), .rst_req_q(reset_req)
  );

  wdog_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                .STAT_ADDR(STAT_ADDR)) u_stat (
    .rd_addr(rd_addr), .cnt(cnt_q), .nmi(nmi), .rd_data(rd_data)
  );
endmodule

// File: rtl/wdog_checker.sv
`timescale 1ns/1ps
module wdog_checker #(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter int                CNT_W     = 9,
  parameter int                KEY_W     = 7,
  parameter int                GRACE     = 1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h44
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_hit,
  input logic              accept,
  input logic              en_q,
  input logic [KEY_W-1:0]  key_q,
  input logic [KEY_W-1:0]  wr_key,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              nmi,
  input logic              reset_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  AST_BAD_KEY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && en_q && (wr_key != ~key_q) && !tick) |=> ($stable(cnt_q) && $stable(nmi) && $stable(key_q))); // R3
  AST_ACCEPT_CLEARS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !nmi); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_hit) |=> $stable(cnt_q)); // R6
  AST_NMI_GRACE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> (cnt_q == CNT_W'(GRACE))); // R7
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req); // R8
  AST_RESET_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (nmi && cnt_q == '0)); // R8
  AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == STAT_ADDR) |-> (rd_data[CNT_W] == nmi && rd_data[CNT_W-1:0] == cnt_q)); // R9
endmodule

bind keyed_wdog wdog_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_W(KEY_W),
  .GRACE(GRACE), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_hit(wr_hit), .accept(accept),
  .en_q(en_q), .key_q(key_q), .wr_key(wr_key), .cnt_q(cnt_q), .nmi(nmi),
  .reset_req(reset_req), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_keyed_wdog.sv
`timescale 1ns/1ps
module sim_keyed_wdog;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = 8'h00;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = 8'h44;
  logic [31:0] rd_data;
  logic        nmi, reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .nmi(nmi),
    .reset_req(reset_req)
  );

  function automatic logic [15:0] mk(input logic [6:0] key, input logic run, input logic [7:0] low);
    return {key, run, low};
  endfunction

  // op: 0 control write, 1 tick, 2 write to status offset
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 16'h2A05, 9'd5,   1'b0},  // R2 disarmed write, key 0x15, stopped, count 5
    {2'd1, 16'h0000, 9'd5,   1'b0},  // R5 stopped counter ignores tick
    {2'd0, 16'h1902, 9'd258, 1'b0},  // R2 key 0x0C run 1, any key taken while disarmed
    {2'd1, 16'h0000, 9'd257, 1'b0},  // R6 one tick
    {2'd0, 16'h1900, 9'd257, 1'b0},  // R3 repeated key 0x0C dropped
    {2'd2, 16'hE700, 9'd257, 1'b0},  // R10 write at 0x44 ignored
    {2'd0, 16'hE701, 9'd257, 1'b0},  // R4 inverted key 0x73 taken, reload 257
    {2'd1, 16'h0000, 9'd256, 1'b0}   // R6 one tick
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic op(input logic [1:0] kind, input logic [15:0] data);
    @(negedge clk);
    tick    = (kind == 2'd1);
    wr_en   = (kind != 2'd1);
    wr_addr = (kind == 2'd2) ? 8'h44 : 8'h40;
    wr_data = {16'h0000, data};
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) op(2'd1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 status", rd_data, 32'h0);
    check("R1 nmi", {31'b0, nmi}, 32'h0);
    check("R1 reset_req", {31'b0, reset_req}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      op(VEC[v][27:26], VEC[v][25:10]);
      check($sformatf("vector %0d cnt", v), {23'b0, rd_data[8:0]}, {23'b0, VEC[v][9:1]});
      check($sformatf("vector %0d nmi", v), {31'b0, rd_data[9]}, {31'b0, VEC[v][0]});
    end

    // R6/R7: run out in the armed stage
    ticks(255);
    check("R6 count at 1", rd_data, 32'h1);
    op(2'd1, 16'h0);
    check("R7 nmi raised", {31'b0, nmi}, 32'h1);
    check("R7 grace load + R9 status", rd_data, 32'h201);
    rd_addr = 8'h40;
    #1 check("R9 other read addr", rd_data, 32'h0);
    rd_addr = 8'h44;

    // R4: refresh in grace with inverted key 0x0C clears nmi
    op(2'd0, mk(7'h0C, 1'b1, 8'h10));
    check("R4 refresh clears nmi", rd_data, 32'h110);
    ticks(271);
    check("R6 count at 1 again", rd_data, 32'h1);
    op(2'd1, 16'h0);
    check("R7 second nmi", rd_data, 32'h201);
    check("R8 no reset yet", {31'b0, reset_req}, 32'h0);
    op(2'd1, 16'h0);
    check("R8 reset pulse", {31'b0, reset_req}, 32'h1);
    check("R8 counter 0, nmi held", rd_data, 32'h200);
    @(negedge clk);
    check("R8 pulse one cycle", {31'b0, reset_req}, 32'h0);
    op(2'd1, 16'h0);
    check("R8 stopped after reset", rd_data, 32'h200);

    // R5: stop with valid key 0x73, then any key taken
    op(2'd0, mk(7'h73, 1'b0, 8'h07));
    check("R5 stop write taken", rd_data, 32'h007);
    op(2'd0, mk(7'h00, 1'b0, 8'h09));
    check("R5 key check off", rd_data, 32'h009);
    ticks(2);
    check("R5 holds on ticks", rd_data, 32'h009);

    // R1: reset mid-run, then any key accepted
    op(2'd0, mk(7'h55, 1'b1, 8'h03));
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 reset clears", rd_data, 32'h0);
    op(2'd0, mk(7'h55, 1'b1, 8'h04));
    check("R1 first write after reset", rd_data, 32'h104);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule